// File: doc/BRIEF.md
# IDCT Coefficient Prescaler

This block sits in front of an 8x8 row-column inverse DCT built on the scaled fast-cosine flow graph. That flow graph leaves a fixed output scale factor on every frequency position. The block folds this factor into the coefficients before the transform starts. Each incoming coefficient is multiplied by an integer weight for its position. A small signed correction term adds a few more bits of precision on top of that weight. The DC coefficient also receives a rounding bias. With that bias in place, the later stage can turn every reconstructed sample back into a pixel with a plain arithmetic right shift by P1.

Coefficients arrive one per cycle. Each one either carries an explicit row and column index, or is counted in raster order by an internal position counter. The scaled value leaves exactly one cycle later with a valid strobe and the position that was used. Both weight tables are constant lookups. They are computed at elaboration from the eight scale factors and the two precision parameters. P1 = 18 with P2 = 3 gives the 32-bit configuration, and P1 = 11 with P2 = 5 gives the 24-bit one.

Top module: `idct_prescale`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` and `out_data` are cleared to 0 after that edge.
- R2: `out_valid` equals the `in_valid` of the previous cycle. A cycle without `in_valid` leaves `out_data` unchanged.
- R3: For a valid coefficient d at a position other than 0, the result is d*W(p) + floor(d*C(p) / 2^P2), where the floor is an arithmetic right shift of the signed product.
- R4: The position is p = 8*row + col, with the row in bits [5:3] and the column in bits [2:0]. With scale factors s0..s7 and x = s_row*s_col*2^P1, the main weight is W = floor(x + 0.5) and the signed correction weight is C = floor((x - W)*2^P2 + 0.5).
- R5: Position 0 (the DC term) additionally receives +2^(P1-1). No other position receives any bias.
- R6: Any result above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) is clamped to that limit.
- R7: When `seq_mode` is 1, the position comes from an internal counter and `in_row`/`in_col` are ignored. The counter starts at 0 after reset and advances by one on each valid beat in this mode, going from 63 back to 0. It does not move on idle cycles or in index mode.
- R8: `out_pos` gives the position that was used for the result in `out_data`.
- R9: With P1 = 11 and P2 = 5, an input of 32 gives 9216 at position (0,0), and 107619 at position (5,5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Coefficient present this cycle |
| in_data | input | IN_W | Signed coefficient |
| seq_mode | input | 1 | 1: raster counter supplies the position; 0: row/column inputs supply it |
| in_row | input | 3 | Row index (index mode) |
| in_col | input | 3 | Column index (index mode) |
| out_valid | output | 1 | Scaled value present |
| out_data | output | OUT_W | Signed scaled coefficient, saturated |
| out_pos | output | 6 | Raster position of the result |

## Verification
A wrong table entry or a wrong counter value cannot stay hidden. It shows up in `out_data` or `out_pos` in the very next cycle after a coefficient reaches the affected position. The bench therefore drives every one of the 64 positions with a set of magnitudes that includes zero, unit steps, odd values and both extremes. Each result is compared against weights that the bench derives itself from the cosine definitions. A raster counter that slips or wraps early is caught by a stream of more than two full blocks, with idle gaps, in counter mode. The rounding-bias path is also checked through the two absolute anchor values of the 24-bit configuration.

// File: rtl/idct_ps_pkg.sv
package idct_ps_pkg;

  localparam int BLK   = 8;
  localparam int NPOS  = BLK * BLK;
  localparam int POS_W = $clog2(NPOS);
  localparam int IDX_W = $clog2(BLK);

  // Output scale factors of the scaled 8-point inverse flow graph
  function automatic real aan_scale(input int k);
    real s;
    case (k)
      0:       s = 0.3535533906;
      1:       s = 0.4499881115;
      2:       s = 0.6532814824;
      3:       s = 0.2548977895;
      4:       s = 0.3535533906;
      5:       s = 1.2814577239;
      6:       s = 0.2705980501;
      7:       s = 0.3006724435;
      default: s = 0.0;
    endcase
    return s;
  endfunction

  function automatic real pow2r(input int n);
    real r;
    r = 1.0;
    for (int i = 0; i < n; i++) r = r * 2.0;
    return r;
  endfunction

  function automatic real scaled_point(input int pos, input int p1);
    return aan_scale(pos / BLK) * aan_scale(pos % BLK) * pow2r(p1);
  endfunction

  // Integer main weight, rounded to nearest
  function automatic int main_weight(input int pos, input int p1);
    return $rtoi($floor(scaled_point(pos, p1) + 0.5));
  endfunction

  // Signed residue of the main weight, expressed in 2^-p2 units
  function automatic int corr_weight(input int pos, input int p1, input int p2);
    real resid;
    resid = scaled_point(pos, p1) - real'(main_weight(pos, p1));
    return $rtoi($floor(resid * pow2r(p2) + 0.5));
  endfunction

endpackage

// File: rtl/idct_ps_pos.sv
module idct_ps_pos
  import idct_ps_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             seq_mode,
  input  logic [IDX_W-1:0] in_row,
  input  logic [IDX_W-1:0] in_col,
  output logic [POS_W-1:0] pos
);

  logic [POS_W-1:0] cnt_q;
  logic             step;

  assign step = in_valid & seq_mode;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (step)
      cnt_q <= (cnt_q == POS_W'(NPOS - 1)) ? '0 : cnt_q + 1'b1;
  end

  assign pos = seq_mode ? cnt_q : {in_row, in_col};

  AST_RASTER_WRAP: assert property (@(posedge clk) disable iff (rst)
    step && cnt_q == POS_W'(NPOS - 1) |=> cnt_q == '0); // R7
  AST_RASTER_STEP: assert property (@(posedge clk) disable iff (rst)
    step && cnt_q != POS_W'(NPOS - 1) |=> cnt_q == POS_W'($past(cnt_q) + 1'b1)); // R7
  AST_RASTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/idct_ps_rom.sv
module idct_ps_rom
  import idct_ps_pkg::*;
#(
  parameter int P1  = 18,
  parameter int P2  = 3,
  parameter int C0W = P1 + 2,
  parameter int C1W = P2 + 2
) (
  input  logic [POS_W-1:0]      pos,
  output logic signed [C0W-1:0] w_main,
  output logic signed [C1W-1:0] w_corr
);

  logic signed [C0W-1:0] tab_main [NPOS];
  logic signed [C1W-1:0] tab_corr [NPOS];

  for (genvar g = 0; g < NPOS; g++) begin : g_tab
    localparam int WM = main_weight(g, P1);
    localparam int WC = corr_weight(g, P1, P2);
    assign tab_main[g] = C0W'(WM);
    assign tab_corr[g] = C1W'(WC);
  end

  assign w_main = tab_main[pos];
  assign w_corr = tab_corr[pos];

endmodule

// File: rtl/idct_ps_mac.sv
module idct_ps_mac
  import idct_ps_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int P1    = 18,
  parameter int P2    = 3,
  parameter int C0W   = P1 + 2,
  parameter int C1W   = P2 + 2,
  parameter int OUT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  din,
  input  logic [POS_W-1:0]        pos,
  input  logic signed [C0W-1:0]   w_main,
  input  logic signed [C1W-1:0]   w_corr,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data,
  output logic [POS_W-1:0]        out_pos
);

  localparam int    PMW    = IN_W + C0W;
  localparam int    PCW    = IN_W + C1W;
  localparam int    SW     = PMW + 2;
  localparam longint BIAS_L = longint'(1) << (P1 - 1);

  logic signed [PMW-1:0]   prod_main;
  logic signed [PCW-1:0]   prod_corr;
  logic signed [PCW-1:0]   corr_sh;
  logic signed [SW-1:0]    bias_v;
  logic signed [SW-1:0]    sum;
  logic signed [OUT_W-1:0] clamped;

  assign prod_main = din * w_main;
  assign prod_corr = din * w_corr;
  assign corr_sh   = prod_corr >>> P2;
  assign bias_v    = (pos == '0) ? SW'(BIAS_L) : '0;
  assign sum       = SW'(prod_main) + SW'(corr_sh) + bias_v;

  if (SW > OUT_W) begin : g_clamp
    localparam logic signed [SW-1:0] MAXS = SW'((longint'(1) << (OUT_W - 1)) - 1);
    localparam logic signed [SW-1:0] MINS = ~MAXS;
    always_comb begin
      if (sum > MAXS)      clamped = {1'b0, {(OUT_W-1){1'b1}}};
      else if (sum < MINS) clamped = {1'b1, {(OUT_W-1){1'b0}}};
      else                 clamped = sum[OUT_W-1:0];
    end
  end else begin : g_wide
    assign clamped = OUT_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_pos   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= clamped;
        out_pos  <= pos;
      end
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data)); // R2

endmodule

// File: rtl/idct_prescale.sv
module idct_prescale
  import idct_ps_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int P1    = 18,
  parameter int P2    = 3,
  parameter int OUT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  input  logic                    seq_mode,
  input  logic [IDX_W-1:0]        in_row,
  input  logic [IDX_W-1:0]        in_col,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data,
  output logic [POS_W-1:0]        out_pos
);

  localparam int C0W = P1 + 2;
  localparam int C1W = P2 + 2;

  logic [POS_W-1:0]      pos_sel;
  logic signed [C0W-1:0] w_main;
  logic signed [C1W-1:0] w_corr;

  idct_ps_pos u_pos (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .seq_mode (seq_mode),
    .in_row   (in_row),
    .in_col   (in_col),
    .pos      (pos_sel)
  );

  idct_ps_rom #(.P1(P1), .P2(P2), .C0W(C0W), .C1W(C1W)) u_rom (
    .pos    (pos_sel),
    .w_main (w_main),
    .w_corr (w_corr)
  );

  idct_ps_mac #(
    .IN_W(IN_W), .P1(P1), .P2(P2), .C0W(C0W), .C1W(C1W), .OUT_W(OUT_W)
  ) u_mac (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .din       (in_data),
    .pos       (pos_sel),
    .w_main    (w_main),
    .w_corr    (w_corr),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_pos   (out_pos)
  );

  AST_POS_ECHO: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_pos == $past(pos_sel)); // R8
  AST_ZERO_AC: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_data == '0 && pos_sel != '0 |=> out_data == '0); // R3

  if (OUT_W > P1) begin : g_dc_chk
    localparam logic signed [OUT_W-1:0] DC_BIAS = OUT_W'(longint'(1) << (P1 - 1));
    AST_DC_BIAS_ONLY: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_data == '0 && pos_sel == '0 |=> out_data == DC_BIAS); // R5
  end

endmodule

// File: tb/sim_idct_prescale.sv
`timescale 1ns/1ps
module sim_idct_prescale;

  localparam int IN_W  = 12;
  localparam int P1    = 11;
  localparam int P2    = 5;
  localparam int OUT_W = 20;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    in_valid = 1'b0;
  logic signed [IN_W-1:0]  in_data = '0;
  logic                    seq_mode = 1'b0;
  logic [2:0]              in_row = '0;
  logic [2:0]              in_col = '0;
  logic                    out_valid;
  logic signed [OUT_W-1:0] out_data;
  logic [5:0]              out_pos;

  always #10 clk = ~clk;

  idct_prescale #(.IN_W(IN_W), .P1(P1), .P2(P2), .OUT_W(OUT_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .seq_mode(seq_mode), .in_row(in_row), .in_col(in_col),
    .out_valid(out_valid), .out_data(out_data), .out_pos(out_pos)
  );

  int  errs = 0;
  int  checks = 0;
  real sc[8];

  logic   pv = 1'b0;
  longint pd = 0;
  int     ppos = 0;
  longint last_out = 0;

  task automatic chk(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic real p2r(input int n);
    real r = 1.0;
    for (int i = 0; i < n; i++) r = r * 2.0;
    return r;
  endfunction

  // R4: weights derived from the cosine definitions
  function automatic longint expect_out(input longint d, input int pos);
    real x;
    longint w0, w1, s, mx;
    x  = sc[pos / 8] * sc[pos % 8] * p2r(P1);
    w0 = longint'($floor(x + 0.5));
    w1 = longint'($floor((x - real'(w0)) * p2r(P2) + 0.5));
    s  = d * w0 + ((d * w1) >>> P2);
    if (pos == 0) s = s + (longint'(1) << (P1 - 1));
    mx = (longint'(1) << (OUT_W - 1)) - 1;
    if (s > mx) s = mx;
    if (s < -mx - 1) s = -mx - 1;
    return s;
  endfunction

  task automatic check_prev();
    longint e;
    if (pv) begin
      chk("R2 valid", longint'(out_valid), 1);
      chk("R8 pos", longint'(out_pos), longint'(ppos));
      e = expect_out(pd, ppos);
      if (ppos == 0)                         chk("R5 dc", longint'(out_data), e);
      else if (e == 524287 || e == -524288)  chk("R6 sat", longint'(out_data), e);
      else                                   chk("R3 R4 scale", longint'(out_data), e);
      last_out = longint'(out_data);
    end else begin
      chk("R2 idle valid", longint'(out_valid), 0);
      chk("R2 idle hold", longint'(out_data), last_out);
    end
  endtask

  task automatic cycle(input logic v, input longint d, input int r, input int c,
                       input logic s, input int epos);
    @(negedge clk);
    check_prev();
    in_valid = v;
    in_data  = d[IN_W-1:0];
    in_row   = r[2:0];
    in_col   = c[2:0];
    seq_mode = s;
    pv = v; pd = d; ppos = epos;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    real pi, r2;
    longint vals[11] = '{-2048, -2047, -1000, -1, 0, 1, 3, 7, 100, 511, 2047};
    pi = 3.14159265358979;
    r2 = $sqrt(2.0);
    sc[0] = 1.0 / (2.0 * r2);
    sc[1] = $cos(7.0*pi/16.0) / (2.0*$sin(3.0*pi/8.0) - r2);
    sc[2] = $cos(pi/8.0) / r2;
    sc[3] = $cos(5.0*pi/16.0) / (r2 + 2.0*$cos(3.0*pi/8.0));
    sc[4] = sc[0];
    sc[5] = $cos(3.0*pi/16.0) / (r2 - 2.0*$cos(3.0*pi/8.0));
    sc[6] = $cos(3.0*pi/8.0) / r2;
    sc[7] = $cos(pi/16.0) / (r2 + 2.0*$sin(3.0*pi/8.0));

    // R1: reset state
    in_valid = 1'b1; in_data = 12'sd77;
    repeat (3) @(negedge clk);
    chk("R1 valid", longint'(out_valid), 0);
    chk("R1 data", longint'(out_data), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // Index mode sweep over every position
    for (int p = 0; p < 64; p++)
      for (int k = 0; k < 11; k++)
        cycle(1'b1, vals[k], p / 8, p % 8, 1'b0, p);
    cycle(1'b0, 0, 0, 0, 1'b0, 0);
    cycle(1'b0, 5, 3, 3, 1'b0, 0);

    // R7: raster counter mode, row/col inputs carry junk
    begin
      int rp = 0;
      for (int k = 0; k < 140; k++) begin
        if (k == 70 || k == 71) cycle(1'b0, 9, 1, 2, 1'b1, 0);
        cycle(1'b1, longint'((k * 37) % 4095) - 2047, 7 - (k % 8), k % 5, 1'b1, rp);
        rp = (rp + 1) % 64;
      end
    end
    cycle(1'b0, 0, 0, 0, 1'b0, 0);

    // R9: absolute anchors of the 24-bit configuration
    cycle(1'b1, 32, 0, 0, 1'b0, 0);
    cycle(1'b0, 0, 0, 0, 1'b0, 0);
    chk("R9 dc anchor", longint'(out_data), 9216);
    cycle(1'b1, 32, 5, 5, 1'b0, 45);
    cycle(1'b0, 0, 0, 0, 1'b0, 0);
    chk("R9 (5,5) anchor", longint'(out_data), 107619);
    cycle(1'b0, 0, 0, 0, 1'b0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule